// File: doc/BRIEF.md
# Privileged Trap Entry Unit

This block performs the state update that happens when a hart takes a trap. A one-cycle request strobe brings in the trap. The strobe carries an interrupt flag, a cause code, the faulting address, the trapping PC and the current privilege level. The unit then chooses the handling level. A trap can be handled at supervisor level only if it comes from supervisor or user level and the matching bit of the relevant delegation mask is set. All other traps go to machine level.

For the chosen level, the unit writes the status fields, the cause register, the exception PC and the trap value register. It computes the handler address from that level's vector register and switches the privilege level. One cycle after the request, a done pulse reports that the new state is visible.

The current interrupt-enable bits arrive as inputs. The enable outputs follow them one cycle later, except at the level that takes a trap, where the enable is forced low. The unit does not decode return-from-trap instructions or CSR accesses.

Top module: `trap_entry`

## Requirements
- R1: While reset is active, privOut is 3 (machine), trapDone is 0, nextPc is 0 and every cause, exception PC, trap value and status output is 0.
- R2: A request is handled at supervisor level (privOut becomes 1) when curPriv is 0 or 1 and the delegation bit indexed by the effective cause is 1. Otherwise it is handled at machine level (privOut becomes 3). A request from curPriv 2 or 3 always goes to machine level.
- R3: When trapAsync is 1, the delegation bit comes from intDeleg. When trapAsync is 0, it comes from excDeleg.
- R4: A synchronous request with cause 8 becomes cause 8, 9, 10 or 11 when curPriv is 0, 1, 2 or 3. This effective cause is used for delegation, for the cause register and for the vector offset. An interrupt with cause 8 is not remapped.
- R5: At the chosen level, the previous-enable output takes the current enable input and the enable output becomes 0. The previous-privilege output takes curPriv: 2 bits at machine level, bit 0 only at supervisor level. The other level's enable output follows its input, and that level's other fields hold.
- R6: The chosen level's cause register receives the effective cause in its low bits, with bit XLEN-1 equal to trapAsync. Its exception PC receives curPc.
- R7: The trap value receives badAddr for synchronous causes 0, 1, 4, 5, 6, 7, 12, 13 and 15. It receives 0 for every other synchronous cause and for all interrupts.
- R8: nextPc is the chosen level's vector with bits 1:0 cleared. When trapAsync is 1 and that vector's bits 1:0 equal 1, the unit adds 4 times the effective cause.
- R9: All outputs change on the clock edge that samples trapReq high. privOut then holds the chosen level, 1 or 3.
- R10: trapDone is high in exactly the cycle after a cycle with trapReq high.
- R11: Without a request, privOut, nextPc, the cause registers, the exception PCs, the trap values and the previous-enable and previous-privilege fields keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trapReq | input | 1 | One-cycle trap request strobe |
| trapAsync | input | 1 | 1 = interrupt, 0 = exception |
| trapCause | input | CAUSE_W | Raw cause code |
| badAddr | input | XLEN | Faulting address |
| curPc | input | XLEN | PC of the trapping instruction |
| curPriv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| curSie | input | 1 | Current supervisor interrupt enable |
| curMie | input | 1 | Current machine interrupt enable |
| intDeleg | input | XLEN | Interrupt delegation mask |
| excDeleg | input | XLEN | Exception delegation mask |
| sVec | input | XLEN | Supervisor trap vector (bits 1:0 = mode) |
| mVec | input | XLEN | Machine trap vector (bits 1:0 = mode) |
| privOut | output | 2 | Privilege after entry |
| nextPc | output | XLEN | Handler address |
| trapDone | output | 1 | Entry complete pulse |
| sIe | output | 1 | Supervisor enable after entry |
| sPie | output | 1 | Supervisor previous enable |
| sPp | output | 1 | Supervisor previous privilege |
| sCause | output | XLEN | Supervisor cause register |
| sEpc | output | XLEN | Supervisor exception PC |
| sTval | output | XLEN | Supervisor trap value |
| mIe | output | 1 | Machine enable after entry |
| mPie | output | 1 | Machine previous enable |
| mPp | output | 2 | Machine previous privilege |
| mCause | output | XLEN | Machine cause register |
| mEpc | output | XLEN | Machine exception PC |
| mTval | output | XLEN | Machine trap value |

## Verification
The hardest case to reach is an environment call whose remapped cause, not the raw one, selects the delegation bit. An example is an ecall from supervisor level with excDeleg bit 9 set and bit 8 clear. A raw-cause lookup would send that trap to the wrong level. Directed sequences create this case and its mirror image for each privilege. They also cover interrupts with cause 8, which must not be remapped, and vectored interrupts raised from machine level while the supervisor vector is also vectored. After that, long random runs mix causes, privileges and masks, and a behavioural model checks every output on every clock.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
  typedef enum logic [1:0] {
    PRIV_U = 2'd0,
    PRIV_S = 2'd1,
    PRIV_H = 2'd2,
    PRIV_M = 2'd3
  } priv_e;

  localparam int unsigned CAUSE_ECALL = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic wrS;      // update supervisor-level state
    logic wrM;      // update machine-level state
    logic useAddr;  // trap value takes the faulting address
    logic vecOff;   // add cause offset to handler base
  } trapStrobe_t;
endpackage

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_entry_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trapReq,
  input  logic               trapAsync,
  input  logic [CAUSE_W-1:0] trapCause,
  input  logic [1:0]         curPriv,
  input  logic [XLEN-1:0]    intDeleg,
  input  logic [XLEN-1:0]    excDeleg,
  input  logic [1:0]         sVecMode,
  input  logic [1:0]         mVecMode,
  output trapStrobe_t        strobe,
  output logic [CAUSE_W-1:0] effCause,
  output logic               trapDone
);
  logic              isEcall;
  logic [XLEN-1:0]   delegMask;
  logic              delegBit;
  logic              toS;
  logic [1:0]        tgtMode;

  assign isEcall = !trapAsync && (trapCause == CAUSE_W'(CAUSE_ECALL));

  // environment call variant follows the privilege it came from
  always_comb begin
    effCause = trapCause;
    if (isEcall) effCause = CAUSE_W'(CAUSE_ECALL) + CAUSE_W'(curPriv);
  end

  assign delegMask = trapAsync ? intDeleg : excDeleg;
  assign delegBit  = delegMask[effCause];
  assign toS       = (curPriv == PRIV_U || curPriv == PRIV_S) && delegBit;
  assign tgtMode   = toS ? sVecMode : mVecMode;

  always_comb begin
    strobe.wrS    = trapReq && toS;
    strobe.wrM    = trapReq && !toS;
    strobe.vecOff = trapAsync && (tgtMode == 2'd1);
    strobe.useAddr = 1'b0;
    if (!trapAsync) begin
      case (effCause)
        CAUSE_W'(0), CAUSE_W'(1), CAUSE_W'(4), CAUSE_W'(5),
        CAUSE_W'(6), CAUSE_W'(7), CAUSE_W'(12), CAUSE_W'(13),
        CAUSE_W'(15): strobe.useAddr = 1'b1;
        default:      strobe.useAddr = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) trapDone <= 1'b0;
    else        trapDone <= trapReq;
  end
endmodule

// File: rtl/trap_entry_dp.sv
module trap_entry_dp
  import trap_entry_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  trapStrobe_t        strobe,
  input  logic [CAUSE_W-1:0] effCause,
  input  logic               trapAsync,
  input  logic [XLEN-1:0]    badAddr,
  input  logic [XLEN-1:0]    curPc,
  input  logic [1:0]         curPriv,
  input  logic               curSie,
  input  logic               curMie,
  input  logic [XLEN-1:0]    sVec,
  input  logic [XLEN-1:0]    mVec,
  output logic [1:0]         privOut,
  output logic [XLEN-1:0]    nextPc,
  output logic               sIe,
  output logic               sPie,
  output logic               sPp,
  output logic [XLEN-1:0]    sCause,
  output logic [XLEN-1:0]    sEpc,
  output logic [XLEN-1:0]    sTval,
  output logic               mIe,
  output logic               mPie,
  output logic [1:0]         mPp,
  output logic [XLEN-1:0]    mCause,
  output logic [XLEN-1:0]    mEpc,
  output logic [XLEN-1:0]    mTval
);
  localparam int PAD_W = XLEN - 1 - CAUSE_W;

  logic [XLEN-1:0] causeVal;
  logic [XLEN-1:0] tvalVal;
  logic [XLEN-1:0] vecBase;
  logic [XLEN-1:0] vecOffset;
  logic [XLEN-1:0] handlerPc;

  assign causeVal  = {trapAsync, {PAD_W{1'b0}}, effCause};
  assign tvalVal   = strobe.useAddr ? badAddr : '0;
  assign vecBase   = (strobe.wrS ? sVec : mVec) & ~XLEN'(3);
  assign vecOffset = strobe.vecOff ? (XLEN'(effCause) << 2) : '0;
  assign handlerPc = vecBase + vecOffset;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      privOut <= PRIV_M;
      nextPc  <= '0;
      sIe     <= 1'b0;
      sPie    <= 1'b0;
      sPp     <= 1'b0;
      sCause  <= '0;
      sEpc    <= '0;
      sTval   <= '0;
      mIe     <= 1'b0;
      mPie    <= 1'b0;
      mPp     <= 2'd0;
      mCause  <= '0;
      mEpc    <= '0;
      mTval   <= '0;
    end else begin
      sIe <= strobe.wrS ? 1'b0 : curSie;
      mIe <= strobe.wrM ? 1'b0 : curMie;
      if (strobe.wrS) begin
        sPie    <= curSie;
        sPp     <= curPriv[0];
        sCause  <= causeVal;
        sEpc    <= curPc;
        sTval   <= tvalVal;
        privOut <= PRIV_S;
        nextPc  <= handlerPc;
      end
      if (strobe.wrM) begin
        mPie    <= curMie;
        mPp     <= curPriv;
        mCause  <= causeVal;
        mEpc    <= curPc;
        mTval   <= tvalVal;
        privOut <= PRIV_M;
        nextPc  <= handlerPc;
      end
    end
  end
endmodule

// File: rtl/trap_entry.sv
module trap_entry
  import trap_entry_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = $clog2(XLEN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trapReq,
  input  logic               trapAsync,
  input  logic [CAUSE_W-1:0] trapCause,
  input  logic [XLEN-1:0]    badAddr,
  input  logic [XLEN-1:0]    curPc,
  input  logic [1:0]         curPriv,
  input  logic               curSie,
  input  logic               curMie,
  input  logic [XLEN-1:0]    intDeleg,
  input  logic [XLEN-1:0]    excDeleg,
  input  logic [XLEN-1:0]    sVec,
  input  logic [XLEN-1:0]    mVec,
  output logic [1:0]         privOut,
  output logic [XLEN-1:0]    nextPc,
  output logic               trapDone,
  output logic               sIe,
  output logic               sPie,
  output logic               sPp,
  output logic [XLEN-1:0]    sCause,
  output logic [XLEN-1:0]    sEpc,
  output logic [XLEN-1:0]    sTval,
  output logic               mIe,
  output logic               mPie,
  output logic [1:0]         mPp,
  output logic [XLEN-1:0]    mCause,
  output logic [XLEN-1:0]    mEpc,
  output logic [XLEN-1:0]    mTval
);
  trapStrobe_t        strobe;
  logic [CAUSE_W-1:0] effCause;

  trap_entry_ctrl #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .trapReq(trapReq), .trapAsync(trapAsync),
    .trapCause(trapCause), .curPriv(curPriv), .intDeleg(intDeleg),
    .excDeleg(excDeleg), .sVecMode(sVec[1:0]), .mVecMode(mVec[1:0]),
    .strobe(strobe), .effCause(effCause), .trapDone(trapDone)
  );

  trap_entry_dp #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .effCause(effCause),
    .trapAsync(trapAsync), .badAddr(badAddr), .curPc(curPc),
    .curPriv(curPriv), .curSie(curSie), .curMie(curMie),
    .sVec(sVec), .mVec(mVec), .privOut(privOut), .nextPc(nextPc),
    .sIe(sIe), .sPie(sPie), .sPp(sPp), .sCause(sCause), .sEpc(sEpc),
    .sTval(sTval), .mIe(mIe), .mPie(mPie), .mPp(mPp), .mCause(mCause),
    .mEpc(mEpc), .mTval(mTval)
  );
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               trapReq,
  input logic               trapAsync,
  input logic [1:0]         curPriv,
  input logic [XLEN-1:0]    curPc,
  input logic [1:0]         privOut,
  input logic [XLEN-1:0]    nextPc,
  input logic               trapDone,
  input logic [XLEN-1:0]    sCause,
  input logic [XLEN-1:0]    sEpc,
  input logic [XLEN-1:0]    sTval,
  input logic               mIe,
  input logic [1:0]         mPp,
  input logic [XLEN-1:0]    mCause,
  input logic [XLEN-1:0]    mEpc,
  input logic [XLEN-1:0]    mTval
);
  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    trapReq |=> trapDone); // R10
  AST_NO_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !trapReq |=> !trapDone); // R10
  AST_MACHINE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (trapReq && curPriv == 2'd3) |=> (privOut == 2'd3 && !mIe && mPp == 2'd3)); // R2
  AST_LEVEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    trapReq |=> (privOut == 2'd1 || privOut == 2'd3)); // R9
  AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    trapReq |=> (((privOut == 2'd3) ? mEpc : sEpc) == $past(curPc))); // R6
  AST_CAUSE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    trapReq |=> (((privOut == 2'd3) ? mCause[XLEN-1] : sCause[XLEN-1]) == $past(trapAsync))); // R6
  AST_INT_NO_TVAL: assert property (@(posedge clk) disable iff (!rst_n)
    (trapReq && trapAsync) |=> (((privOut == 2'd3) ? mTval : sTval) == '0)); // R7
  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    trapReq |=> (nextPc[1:0] == 2'b00)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !trapReq |=> ($stable(privOut) && $stable(nextPc) && $stable(mEpc) && $stable(sEpc)
                  && $stable(mCause) && $stable(sCause))); // R11
endmodule

bind trap_entry trap_entry_chk #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_chk (.*);

// File: tb/trap_entry_bench.sv
module trap_entry_bench;
  localparam int XLEN = 32;
  localparam int CW   = 5;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n;
  logic trapReq, trapAsync, curSie, curMie;
  logic [CW-1:0] trapCause;
  logic [XLEN-1:0] badAddr, curPc, intDeleg, excDeleg, sVec, mVec;
  logic [1:0] curPriv;
  logic [1:0] privOut, mPp;
  logic [XLEN-1:0] nextPc, sCause, sEpc, sTval, mCause, mEpc, mTval;
  logic trapDone, sIe, sPie, sPp, mIe, mPie;

  // model state
  logic [1:0] ePriv, eMPp;
  logic [XLEN-1:0] eNext, eSCause, eSEpc, eSTval, eMCause, eMEpc, eMTval;
  logic eDone, eSIe, eSPie, eSPp, eMIe, eMPie;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_entry u_trap_entry (
    .clk(clk), .rst_n(rst_n), .trapReq(trapReq), .trapAsync(trapAsync),
    .trapCause(trapCause), .badAddr(badAddr), .curPc(curPc),
    .curPriv(curPriv), .curSie(curSie), .curMie(curMie),
    .intDeleg(intDeleg), .excDeleg(excDeleg), .sVec(sVec), .mVec(mVec),
    .privOut(privOut), .nextPc(nextPc), .trapDone(trapDone),
    .sIe(sIe), .sPie(sPie), .sPp(sPp), .sCause(sCause), .sEpc(sEpc),
    .sTval(sTval), .mIe(mIe), .mPie(mPie), .mPp(mPp), .mCause(mCause),
    .mEpc(mEpc), .mTval(mTval)
  );

  task automatic chk(input string what, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s at %0t: actual %h expected %h", what, $time, act, exp);
    end
  endtask

  task automatic compareAll(input bit inReset);
    if (inReset) begin
      chk("R1 reset privOut", XLEN'(privOut), 3);
      chk("R1 reset nextPc", nextPc, 0);
      chk("R1 reset done", XLEN'(trapDone), 0);
      chk("R1 reset mCause", mCause, 0);
      chk("R1 reset sCause", sCause, 0);
      chk("R1 reset status", XLEN'({sIe, sPie, sPp, mIe, mPie, mPp}), 0);
      chk("R1 reset epc/tval", sEpc | mEpc | sTval | mTval, 0);
    end else begin
      chk("R2 R3 R9 privOut", XLEN'(privOut), XLEN'(ePriv));
      chk("R8 R11 nextPc", nextPc, eNext);
      chk("R10 trapDone", XLEN'(trapDone), XLEN'(eDone));
      chk("R4 R6 R11 sCause", sCause, eSCause);
      chk("R4 R6 R11 mCause", mCause, eMCause);
      chk("R6 R11 sEpc", sEpc, eSEpc);
      chk("R6 R11 mEpc", mEpc, eMEpc);
      chk("R7 sTval", sTval, eSTval);
      chk("R7 mTval", mTval, eMTval);
      chk("R5 sup status", XLEN'({sIe, sPie, sPp}), XLEN'({eSIe, eSPie, eSPp}));
      chk("R5 mach status", XLEN'({mIe, mPie, mPp}), XLEN'({eMIe, eMPie, eMPp}));
    end
  endtask

  // behavioural model of the next state, from the requirements
  task automatic modelStep();
    int c;
    bit dbit, toS, addrCause;
    logic [XLEN-1:0] cv, tv, vec, np;
    eDone = trapReq;
    eSIe = curSie;
    eMIe = curMie;
    if (trapReq) begin
      c = int'(trapCause);
      if (!trapAsync && c == 8) c = 8 + int'(curPriv);
      dbit = trapAsync ? intDeleg[c] : excDeleg[c];
      toS = (curPriv <= 2'd1) && dbit;
      addrCause = !trapAsync && (c == 0 || c == 1 || c == 4 || c == 5 || c == 6 ||
                                 c == 7 || c == 12 || c == 13 || c == 15);
      tv = addrCause ? badAddr : 0;
      cv = XLEN'(c);
      cv[XLEN-1] = trapAsync;
      vec = toS ? sVec : mVec;
      np = {vec[XLEN-1:2], 2'b00};
      if (trapAsync && vec[1:0] == 2'd1) np = np + XLEN'(4 * c);
      eNext = np;
      if (toS) begin
        eSPie = curSie; eSPp = curPriv[0]; eSIe = 1'b0;
        eSCause = cv; eSEpc = curPc; eSTval = tv; ePriv = 2'd1;
      end else begin
        eMPie = curMie; eMPp = curPriv; eMIe = 1'b0;
        eMCause = cv; eMEpc = curPc; eMTval = tv; ePriv = 2'd3;
      end
    end
  endtask

  // one clock: check at negedge, then drive, then advance the model
  task automatic cycle(input bit rq, input bit as, input int cause, input logic [1:0] pr,
                       input logic [XLEN-1:0] idel, input logic [XLEN-1:0] edel,
                       input logic [XLEN-1:0] sv, input logic [XLEN-1:0] mv);
    @(negedge clk);
    compareAll(0);
    trapReq = rq; trapAsync = as; trapCause = CW'(cause); curPriv = pr;
    intDeleg = idel; excDeleg = edel; sVec = sv; mVec = mv;
    curPc = $urandom; badAddr = $urandom;
    curSie = $urandom_range(0, 1); curMie = $urandom_range(0, 1);
    modelStep();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    trapReq = 0; trapAsync = 0; trapCause = 0; curPriv = 0; curSie = 1; curMie = 1;
    badAddr = 0; curPc = 0; intDeleg = 0; excDeleg = 0; sVec = 0; mVec = 0;
    ePriv = 2'd3; eNext = 0; eDone = 0; eSIe = 0; eSPie = 0; eSPp = 0; eMIe = 0;
    eMPie = 0; eMPp = 0; eSCause = 0; eSEpc = 0; eSTval = 0; eMCause = 0; eMEpc = 0;
    eMTval = 0;
    // R1: check with a pending request held during reset
    trapReq = 1;
    repeat (3) begin
      @(negedge clk);
      compareAll(1);
    end
    trapReq = 0;
    rst_n = 1'b1;
    // inputs during the reset-exit edge: no request, enables follow
    eSIe = curSie; eMIe = curMie;

    // R4 R2: ecall from S, only bit 9 delegated, lands at S
    cycle(1, 0, 8, 2'd1, 0, 32'h0000_0200, 32'h0000_1000, 32'h0000_2000);
    // R4: ecall from S with only bit 8 delegated, goes to M
    cycle(1, 0, 8, 2'd1, 0, 32'h0000_0100, 32'h0000_1000, 32'h0000_2000);
    // R4: ecall from U, H-encoded and M
    cycle(1, 0, 8, 2'd0, 0, 32'h0000_0100, 32'h0000_1000, 32'h0000_2000);
    cycle(1, 0, 8, 2'd2, 0, 32'hFFFF_FFFF, 32'h0000_1000, 32'h0000_2000);
    cycle(1, 0, 8, 2'd3, 0, 32'hFFFF_FFFF, 32'h0000_1000, 32'h0000_2000);
    // R4 R3: interrupt cause 8 is not remapped, uses intDeleg
    cycle(1, 1, 8, 2'd1, 32'h0000_0100, 0, 32'h0000_1001, 32'h0000_2001);
    // R8: vectored interrupt from M, supervisor vector also vectored
    cycle(1, 1, 7, 2'd3, 32'hFFFF_FFFF, 0, 32'h0000_1001, 32'h0000_2001);
    // R8: vectored mode but exception, no offset
    cycle(1, 0, 2, 2'd3, 0, 0, 32'h0000_1001, 32'h0000_2001);
    // R8: mode 2 interrupt, no offset
    cycle(1, 1, 5, 2'd0, 0, 0, 32'h0000_1002, 32'h0000_2002);
    // R7: address causes and a non-address cause, delegated to S
    for (int k = 0; k < 16; k++) cycle(1, 0, k, 2'd0, 0, 32'h0000_FFFF, 32'h0000_3000, 32'h0);
    // R11: idle cycles hold state
    repeat (4) cycle(0, 0, 0, 2'd0, 0, 0, 32'h0000_4000, 32'h0000_5000);
    // R10 back-to-back requests
    cycle(1, 1, 3, 2'd3, 0, 0, 0, 32'h0000_0101);
    cycle(1, 1, 11, 2'd3, 0, 0, 0, 32'h0000_0101);

    for (int n = 0; n < 4000; n++) begin
      cycle($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 15),
            2'($urandom_range(0, 3)), $urandom, $urandom, $urandom, $urandom);
    end
    @(negedge clk);
    compareAll(0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule